// File: doc/BRIEF.md
# Nibble-Split 8x8 Unsigned Multiplier

This block multiplies two unsigned 8-bit operands and returns their 16-bit product. It is purely combinational: there are no registers, no clock and no reset, and the output follows the inputs after the logic settles.

Each operand is cut into a high and a low 4-bit nibble. Four identical 4x4 AND-and-full-adder arrays produce the nibble products low·low, high·low, low·high and high·high. The four array instances come from one parameterised generate structure.

- The lowest four product bits are taken directly from the low·low array.
- The middle weights pass through two 3-input carry-save groups. Each group yields a sum vector and a carry vector, and the carry vector is presented one position further left.
- The upper half of the high·high product bypasses the carry-save groups.
- A single 12-bit carry-propagate adder then forms product bits 15..4. Its carry out is dropped, because an 8x8 unsigned product always fits in 16 bits.

Top module: `nib_mult8`

## Requirements
- R1: For every pair of 8-bit unsigned operands, `prod` equals the arithmetic product `a*b`.
- R2: `prod[3:0]` equals the low four bits of `a[3:0]*b[3:0]` and does not depend on `a[7:4]` or `b[7:4]`.
- R3: When either operand is zero, `prod` is zero.
- R4: With both operands at 255, `prod` is 16'hFE01, with no wrap-around.
- R5: Each 4x4 array yields the exact 8-bit product of its two nibbles. With both high nibbles zero, `prod` equals `a[3:0]*b[3:0]`. With both low nibbles zero, `prod` equals `(a[7:4]*b[7:4])<<8`.
- R6: The carry-save stage preserves value: sum plus twice the carry equals the sum of its three inputs in each group.
- R7: The carry out of the 12-bit final adder is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | Unsigned multiplicand |
| b | input | 8 | Unsigned multiplier |
| prod | output | 16 | Unsigned product |

## Verification
A wrong cell in one of the 4x4 arrays, or a wrong carry-save bit, shows up at once as a wrong product. It appears in the same evaluation as the input change, because nothing is stored. Because each array covers a separate quarter of the input space, the operand patterns that isolate one array (both high nibbles zero, or both low nibbles zero) point to the faulty array. A misaligned carry vector distorts the middle product bits for any operand pair whose cross products carry. The exhaustive sweep of all 65536 pairs therefore exposes such a fault within the first few hundred pairs.

// File: rtl/nib_mult8.sv
module nib_mult8 #(
  parameter int NIB = 4
) (
  input  logic [2*NIB-1:0] a,
  input  logic [2*NIB-1:0] b,
  output logic [4*NIB-1:0] prod
);
  localparam int W  = 2 * NIB;
  localparam int FW = 3 * NIB;

  logic [W-1:0] pp [4];

  for (genvar m = 0; m < 4; m++) begin : g_arr
    logic [NIB-1:0] opa, opb;
    logic [NIB:0][NIB:0] sm;
    logic [NIB-1:0][NIB:0] cy;

    assign opa = (m % 2 == 1) ? a[W-1:NIB] : a[NIB-1:0];
    assign opb = (m / 2 == 1) ? b[W-1:NIB] : b[NIB-1:0];

    for (genvar i = 0; i < NIB; i++) begin : g_row
      for (genvar j = 0; j < NIB; j++) begin : g_col
        logic x, si, ci;
        assign x  = opa[i] & opb[j];
        assign si = sm[i][j+1];
        assign ci = cy[i][j];
        assign sm[i+1][j]  = si ^ x ^ ci;
        assign cy[i][j+1]  = (si & x) | (ci & (si ^ x));
        if (i == 0) begin : g_top
          assign sm[0][j+1] = 1'b0;
        end
        if (j == NIB-1) begin : g_left
          assign sm[i+1][NIB] = cy[i][NIB];
        end
        if (j == 0) begin : g_right
          assign cy[i][0] = 1'b0;
          assign pp[m][i] = sm[i+1][0];
        end
        if (i == NIB-1) begin : g_bot
          assign pp[m][NIB+j] = sm[NIB][j+1];
        end
      end
    end

    if (m == 0) begin : g_unused_top
      logic unused_top;
      assign unused_top = sm[0][0];
    end else begin : g_unused_top_n
      logic unused_top;
      assign unused_top = sm[0][0];
    end

    always_comb begin
      AST_SUBARRAY_OK: assert (pp[m] == W'(opa) * W'(opb))  // R5
        else $error("array %0d: %h*%h gave %h", m, opa, opb, pp[m]);
    end
  end

  logic [NIB-1:0] ll_h, hl_l, hl_h, lh_l, lh_h, hh_l, hh_h;
  assign ll_h = pp[0][W-1:NIB];
  assign hl_l = pp[1][NIB-1:0];
  assign hl_h = pp[1][W-1:NIB];
  assign lh_l = pp[2][NIB-1:0];
  assign lh_h = pp[2][W-1:NIB];
  assign hh_l = pp[3][NIB-1:0];
  assign hh_h = pp[3][W-1:NIB];

  logic [NIB-1:0] s_lo, c_lo, s_hi, c_hi;
  assign s_lo = hl_l ^ lh_l ^ ll_h;
  assign c_lo = (hl_l & lh_l) | (hl_l & ll_h) | (lh_l & ll_h);
  assign s_hi = hl_h ^ lh_h ^ hh_l;
  assign c_hi = (hl_h & lh_h) | (hl_h & hh_l) | (lh_h & hh_l);

  logic [FW-1:0] va, vb;
  logic [FW:0]   fsum;
  assign va   = {hh_h, s_hi, s_lo};
  assign vb   = {{(NIB-1){1'b0}}, c_hi, c_lo, 1'b0};
  assign fsum = {1'b0, va} + {1'b0, vb};

  assign prod = {fsum[FW-1:0], pp[0][NIB-1:0]};

  always_comb begin
    AST_CSA_LOW_KEEPS_VALUE: assert ((W'(s_lo) + (W'(c_lo) << 1)) == (W'(hl_l) + W'(lh_l) + W'(ll_h)))  // R6
      else $error("low carry-save group lost value");
    AST_CSA_HIGH_KEEPS_VALUE: assert ((W'(s_hi) + (W'(c_hi) << 1)) == (W'(hl_h) + W'(lh_h) + W'(hh_l)))  // R6
      else $error("high carry-save group lost value");
    AST_NO_OVERFLOW: assert (fsum[FW] == 1'b0)  // R7
      else $error("final adder carried out");
    AST_PRODUCT_MATCH: assert (prod == (4*NIB)'(a) * (4*NIB)'(b))  // R1
      else $error("product %h for %h*%h", prod, a, b);
  end
endmodule

// File: tb/sim_nib_mult8.sv
module sim_nib_mult8;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]  a = '0, b = '0;
  logic [15:0] prod;

  nib_mult8 u0 (.a(a), .b(b), .prod(prod));

  logic [31:0] q [$];
  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] x, input logic [7:0] y);
    @(posedge clk);
    a = x;
    b = y;
    q.push_back({x, y, 16'(x) * 16'(y)});
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        logic [31:0] it;
        logic [7:0] x, y;
        logic [15:0] e;
        it = q.pop_front();
        x = it[31:24];
        y = it[23:16];
        e = it[15:0];
        chk(prod == e, "R1", prod, e);
        chk(prod[3:0] == 4'((x[3:0] * y[3:0]) & 8'hF), "R2", {12'b0, prod[3:0]},
            {12'b0, 4'(x[3:0] * y[3:0])});
        if (x == 0 || y == 0) chk(prod == 16'h0, "R3", prod, 16'h0);
        if (x == 8'hFF && y == 8'hFF) chk(prod == 16'hFE01, "R4 R7", prod, 16'hFE01);
        if (x[7:4] == 0 && y[7:4] == 0)
          chk(prod == 16'(x[3:0] * y[3:0]), "R5 low array", prod, 16'(x[3:0] * y[3:0]));
        if (x[3:0] == 0 && y[3:0] == 0)
          chk(prod == {8'(x[7:4] * y[7:4]), 8'h00}, "R5 high array", prod, {8'(x[7:4] * y[7:4]), 8'h00});
      end
    end
  end

  initial begin : driver
    #1;
    @(negedge clk);
    chk(prod == 16'h0, "R3 idle zero", prod, 16'h0);
    // R6: cross products with heavy carries
    drive(8'hFF, 8'hFF);
    drive(8'h0F, 8'hF0);
    drive(8'hF0, 8'h0F);
    // R2: same low nibbles, differing high nibbles
    drive(8'h37, 8'hA9);
    drive(8'hC7, 8'h59);
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        drive(8'(i), 8'(j));
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule